// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker with Colour Table

This block sits between a framebuffer fetch engine and an LCD panel timing stage. It receives a stream of 32-bit memory words over a valid/ready handshake, cuts them into pixels according to a 4-bit format selector, and delivers one 24-bit RGB pixel per output handshake. Words are treated as a little-endian byte stream. Pixel sizes of one, two, three or four bytes are handled, including three-byte pixels that straddle word boundaries.

The upper three bits of the format selector choose the memory layout. The low bit gives the channel order in memory. That bit is XORed with a static panel-side swap input, and when the result is 1 the red and blue channels of every output pixel are exchanged. In the one-byte layout each byte indexes a 256-entry colour table. The table is loaded through a two-step write port: a colour is first staged, then committed by a keyed control write. The table is inferred as a simple dual-port block RAM, so the stream keeps running while entries are rewritten.

Top module: `fb_pixel_unpacker`

## Requirements
- R1: After reset, o_valid is 0 and i_ready is 1.
- R2: Layout 0 (fmt_sel[3:1]=0) reads 16-bit pixels, lower halfword first. Red is bits 15:11, green 10:5 and blue 4:0. Each channel is widened to 8 bits by repeating its top bits below it, so 5'b11111 becomes 8'hFF.
- R3: Layout 1 reads 16-bit pixels, lower halfword first. Red is bits 14:10, green 9:5 and blue 4:0, each widened as in R2. Bit 15 has no effect on the output.
- R4: Layout 2 reads 3-byte pixels from the byte stream: first byte blue, second green, third red. Pixels straddle words, and three words give exactly four pixels.
- R5: Layouts 3 and 4 read one pixel per word: red 23:16, green 15:8, blue 7:0. Bits 31:24 have no effect. Codes 6 and 7 behave like layout 3.
- R6: Layout 5 reads one byte per pixel, byte 0 of the word first. Each byte indexes the colour table, whose 24-bit entries output red 23:16, green 15:8, blue 7:0.
- R7: When fmt_sel[0] XOR panel_swap is 1, red and blue of every output pixel are exchanged. When it is 0 they are not.
- R8: A write with cfg_sel=0 stages cfg_wdata[23:0]. A write with cfg_sel=1 commits the staged colour to entry cfg_wdata[7:0] only if cfg_wdata[15:8] is 8'h83. Any other key leaves the table unchanged.
- R9: A table commit does not stall the stream. A pixel already looked up keeps its colour. Every pixel looked up after the commit cycle uses the new colour.
- R10: While o_valid is 1 and o_ready is 0, o_valid and o_rgb hold. Pixels leave in stream order with none lost or repeated under any valid/ready pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 4 | Layout in bits 3:1, memory channel order in bit 0; change only while idle |
| panel_swap | input | 1 | Panel-side red/blue swap, XORed with fmt_sel[0] |
| cfg_wr | input | 1 | Colour table port write strobe |
| cfg_sel | input | 1 | 0: stage colour, 1: keyed commit |
| cfg_wdata | input | 32 | Colour (23:0) or key (15:8) plus entry index (7:0) |
| i_valid | input | 1 | Fetched word valid |
| i_data | input | 32 | Fetched word |
| i_ready | output | 1 | Block can accept a word |
| o_valid | output | 1 | Pixel valid |
| o_rgb | output | 24 | Pixel, red 23:16, green 15:8, blue 7:0 |
| o_ready | input | 1 | Panel side accepts the pixel |

## Verification
A colour table commit can fall in the same cycle as a table lookup for the pixel stream, and the two can target the same entry. The bench provokes this by holding o_ready low while a word of four identical indices waits in the block. It then commits a new colour to that entry and releases o_ready. The first pixel must show the old colour and the three after it the new one. Buffer fill and drain coincide on most cycles of the randomised runs, and the ordering check over all layouts judges those cycles.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  typedef enum logic [2:0] {
    LAY_HALF565  = 3'd0,
    LAY_HALF555  = 3'd1,
    LAY_TRIPLE   = 3'd2,
    LAY_WORD     = 3'd3,
    LAY_WORD_A   = 3'd4,
    LAY_INDEX    = 3'd5,
    LAY_RSVD6    = 3'd6,
    LAY_RSVD7    = 3'd7
  } layout_e;

  localparam int CH_W = 8;
  localparam logic [7:0] PAL_COMMIT_KEY = 8'h83;

  function automatic logic [2:0] bytes_of(layout_e lay);
    case (lay)
      LAY_HALF565, LAY_HALF555: bytes_of = 3'd2;
      LAY_TRIPLE:               bytes_of = 3'd3;
      LAY_INDEX:                bytes_of = 3'd1;
      default:                  bytes_of = 3'd4;
    endcase
  endfunction

  function automatic logic [7:0] widen5(logic [4:0] v);
    widen5 = {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(logic [5:0] v);
    widen6 = {v, v[5:4]};
  endfunction
endpackage

// File: rtl/pxu_palette.sv
module pxu_palette #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  AST_PAL_COMMIT: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata)); // R8
endmodule

// File: rtl/pxu_bytebuf.sv
module pxu_bytebuf #(
  parameter int IN_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  i_valid,
  input  logic [IN_W-1:0]       i_data,
  output logic                  i_ready,
  input  logic                  take,
  input  logic [$clog2(2*IN_W/8+1)-1:0] take_n,
  output logic [$clog2(2*IN_W/8+1)-1:0] avail,
  output logic [IN_W-1:0]       head
);
  localparam int NB    = IN_W / 8;
  localparam int BUF_B = 2 * NB;
  localparam int CW    = $clog2(BUF_B + 1);

  logic [BUF_B*8-1:0] buf_q, buf_d;
  logic [CW-1:0]      cnt_q, cnt_d, used, rem;
  logic               accept;

  assign i_ready = (cnt_q <= CW'(NB));
  assign accept  = i_valid && i_ready;
  assign avail   = cnt_q;
  assign head    = buf_q[IN_W-1:0];
  assign used    = take ? take_n : '0;
  assign rem     = cnt_q - used;

  always_comb begin
    buf_d = buf_q >> (8 * used);
    if (accept) begin
      for (int b = 0; b < BUF_B; b++) begin
        if (b >= int'(rem) && b < int'(rem) + NB)
          buf_d[b*8 +: 8] = i_data[(b - int'(rem))*8 +: 8];
      end
    end
    cnt_d = rem + (accept ? CW'(NB) : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      buf_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      buf_q <= buf_d;
    end
  end

  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(BUF_B)); // R4
  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
    take |-> cnt_q >= take_n); // R10
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    (accept && !take) |=> cnt_q == $past(cnt_q) + CW'(NB)); // R4
endmodule

// File: rtl/pxu_decode.sv
module pxu_decode
  import pxu_pkg::*;
(
  input  layout_e     layout,
  input  logic        swap,
  input  logic [31:0] raw,
  input  logic [23:0] pal_rgb,
  output logic [23:0] rgb
);
  logic [CH_W-1:0] r, g, b;
  logic unused_hi;

  assign unused_hi = ^raw[31:24];

  always_comb begin
    case (layout)
      LAY_HALF565: begin
        r = widen5(raw[15:11]);
        g = widen6(raw[10:5]);
        b = widen5(raw[4:0]);
      end
      LAY_HALF555: begin
        r = widen5(raw[14:10]);
        g = widen5(raw[9:5]);
        b = widen5(raw[4:0]);
      end
      LAY_INDEX: begin
        r = pal_rgb[23:16];
        g = pal_rgb[15:8];
        b = pal_rgb[7:0];
      end
      default: begin
        r = raw[23:16];
        g = raw[15:8];
        b = raw[7:0];
      end
    endcase
    rgb = swap ? {b, g, r} : {r, g, b};
  end
endmodule

// File: rtl/fb_pixel_unpacker.sv
module fb_pixel_unpacker
  import pxu_pkg::*;
#(
  parameter int IN_W   = 32,
  parameter int RGB_W  = 24,
  parameter int PAL_AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       fmt_sel,
  input  logic             panel_swap,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             i_valid,
  input  logic [IN_W-1:0]  i_data,
  output logic             i_ready,
  output logic             o_valid,
  output logic [RGB_W-1:0] o_rgb,
  input  logic             o_ready
);
  localparam int CW = $clog2(2 * IN_W / 8 + 1);

  layout_e          layout;
  logic             swap;
  logic [CW-1:0]    need, avail;
  logic [IN_W-1:0]  head;
  logic             s1_load, s1_valid;
  logic [IN_W-1:0]  s1_raw;
  logic [RGB_W-1:0] stage_q, pal_rgb;
  logic             commit;
  logic             unused_cfg;

  assign layout  = layout_e'(fmt_sel[3:1]);
  assign swap    = fmt_sel[0] ^ panel_swap;
  assign need    = CW'(bytes_of(layout));
  assign s1_load = (avail >= need) && (!s1_valid || o_ready);
  assign commit  = cfg_wr && cfg_sel && (cfg_wdata[15:8] == PAL_COMMIT_KEY);
  assign unused_cfg = ^cfg_wdata[31:24];

  pxu_bytebuf #(.IN_W(IN_W)) u_buf (
    .clk(clk), .rst(rst),
    .i_valid(i_valid), .i_data(i_data), .i_ready(i_ready),
    .take(s1_load), .take_n(need), .avail(avail), .head(head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (cfg_wr && !cfg_sel) begin
      stage_q <= cfg_wdata[RGB_W-1:0];
    end
  end

  pxu_palette #(.AW(PAL_AW), .DW(RGB_W)) u_pal (
    .clk(clk), .rst(rst),
    .we(commit), .waddr(cfg_wdata[PAL_AW-1:0]), .wdata(stage_q),
    .re(s1_load), .raddr(head[PAL_AW-1:0]), .rdata(pal_rgb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_raw   <= '0;
    end else begin
      if (s1_load) begin
        s1_valid <= 1'b1;
        s1_raw   <= head;
      end else if (o_ready) begin
        s1_valid <= 1'b0;
      end
    end
  end

  pxu_decode u_dec (
    .layout(layout), .swap(swap), .raw(s1_raw[31:0]),
    .pal_rgb(pal_rgb), .rgb(o_rgb)
  );

  assign o_valid = s1_valid;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !o_ready) |=> (s1_valid && $stable(s1_raw))); // R10
  AST_LOOKUP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !o_ready) |=> $stable(pal_rgb)); // R9
  AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (rst)
    s1_load |=> o_valid); // R10
endmodule

// File: tb/test_fb_pixel_unpacker.sv
module test_fb_pixel_unpacker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  fmt_sel;
  logic        panel_swap;
  logic        cfg_wr, cfg_sel;
  logic [31:0] cfg_wdata;
  logic        i_valid;
  logic [31:0] i_data;
  logic        i_ready;
  logic        o_valid;
  logic [23:0] o_rgb;
  logic        o_ready;

  int checks = 0;
  int errors = 0;

  logic [23:0] pal_m [256];
  logic [31:0] words [16];
  logic [23:0] exp_q [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_pixel_unpacker i_fb_pixel_unpacker (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .panel_swap(panel_swap),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .i_valid(i_valid), .i_data(i_data), .i_ready(i_ready),
    .o_valid(o_valid), .o_rgb(o_rgb), .o_ready(o_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] w5(input logic [4:0] v);
    return (8'(v) << 3) | (8'(v) >> 2);
  endfunction

  function automatic logic [7:0] w6(input logic [5:0] v);
    return (8'(v) << 2) | (8'(v) >> 4);
  endfunction

  function automatic int pix_bytes(input int lay);
    if (lay == 0 || lay == 1) return 2;
    if (lay == 2) return 3;
    if (lay == 5) return 1;
    return 4;
  endfunction

  function automatic logic [23:0] expect_pix(input int lay, input logic sw, input logic [31:0] v);
    logic [7:0] r, g, b;
    case (lay)
      0: begin r = w5(v[15:11]); g = w6(v[10:5]); b = w5(v[4:0]); end
      1: begin r = w5(v[14:10]); g = w5(v[9:5]);  b = w5(v[4:0]); end
      5: begin r = pal_m[v[7:0]][23:16]; g = pal_m[v[7:0]][15:8]; b = pal_m[v[7:0]][7:0]; end
      default: begin r = v[23:16]; g = v[15:8]; b = v[7:0]; end
    endcase
    return sw ? {b, g, r} : {r, g, b};
  endfunction

  function automatic string tag_of(input int lay);
    case (lay)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      5: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic pal_write(input logic [7:0] idx, input logic [23:0] col, input logic [7:0] key);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = {8'h00, col};
    @(negedge clk);
    cfg_sel = 1'b1; cfg_wdata = {16'h0000, key, idx};
    @(negedge clk);
    cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    if (key == 8'h83) pal_m[idx] = col;
  endtask

  task automatic run_stream(input logic [3:0] fmt, input logic psw, input int nwords);
    int lay, nb, npix, wi, got, guard;
    logic sw;
    logic [31:0] v;
    logic stalled;
    logic [23:0] held;
    lay = int'(fmt[3:1]);
    sw  = fmt[0] ^ psw;
    nb  = pix_bytes(lay);
    npix = nwords * 4 / nb;
    for (int p = 0; p < npix; p++) begin
      v = '0;
      for (int k = 0; k < nb; k++) begin
        int bi;
        bi = p * nb + k;
        v[k*8 +: 8] = words[bi/4][(bi%4)*8 +: 8];
      end
      exp_q[p] = expect_pix(lay, sw, v);
    end
    @(negedge clk);
    fmt_sel = fmt; panel_swap = psw;
    wi = 0; got = 0; guard = 0; stalled = 1'b0; held = '0;
    while (got < npix && guard < 3000) begin
      @(negedge clk);
      guard++;
      i_valid = (wi < nwords) && ($urandom % 4 != 0);
      i_data  = (wi < nwords) ? words[wi] : 32'h0;
      o_ready = ($urandom % 4 != 0);
      #1;
      if (stalled) begin
        check("R10 hold valid", 32'(o_valid), 32'd1);
        check("R10 hold data", 32'(o_rgb), 32'(held));
      end
      if (o_valid && o_ready) begin
        check(sw ? {tag_of(lay), " R7"} : tag_of(lay), 32'(o_rgb), 32'(exp_q[got]));
        got++;
      end
      if (i_valid && i_ready) wi++;
      stalled = o_valid && !o_ready;
      held = o_rgb;
    end
    check("R10 stream complete", 32'(got), 32'(npix));
    @(negedge clk);
    i_valid = 1'b0; o_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; fmt_sel = '0; panel_swap = 1'b0;
    cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    i_valid = 1'b0; i_data = '0; o_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 o_valid", 32'(o_valid), 32'd0);
    check("R1 i_ready", 32'(i_ready), 32'd1);

    for (int e = 0; e < 256; e++) pal_write(8'(e), 24'($urandom), 8'h83);

    // R8: wrong key must not commit; entry 7 observed through a palette stream
    pal_write(8'd7, 24'hABCDEF ^ pal_m[7], 8'h84);
    for (int i = 0; i < 3; i++) words[i] = 32'h07070707;
    run_stream(4'd10, 1'b0, 3);
    check("R8 key rejected", 32'(pal_m[7] != (24'hABCDEF ^ pal_m[7])), 32'd1);

    // Directed corners: 565 all ones / zero, 1555 with top bit only
    words[0] = 32'h0000FFFF; words[1] = 32'hF800_07E0; words[2] = 32'h001F_8000;
    run_stream(4'd0, 1'b0, 3);
    words[0] = 32'h8000_FFFF; words[1] = 32'h7C00_801F; words[2] = 32'h03E0_0000;
    run_stream(4'd2, 1'b0, 3);
    words[0] = 32'hFF112233; words[1] = 32'h00445566; words[2] = 32'h80778899;
    run_stream(4'd6, 1'b1, 3);

    // Random sweep over every code and both panel settings
    for (int f = 0; f < 16; f++) begin
      for (int ps = 0; ps < 2; ps++) begin
        for (int i = 0; i < 12; i++) words[i] = $urandom;
        run_stream(4'(f), 1'(ps), 12);
      end
    end

    // R9: commit to an entry while its first pixel waits at the output
    pal_write(8'd5, 24'h102030, 8'h83);
    @(negedge clk);
    fmt_sel = 4'd10; panel_swap = 1'b0; o_ready = 1'b0;
    i_valid = 1'b1; i_data = 32'h05050505;
    @(negedge clk);
    i_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R9 first pixel waiting", 32'(o_valid), 32'd1);
    pal_write(8'd5, 24'hC0FFEE, 8'h83);
    #1;
    check("R9 held colour during commit", 32'(o_rgb), 32'h102030);
    begin
      int got, guard;
      got = 0; guard = 0;
      while (got < 4 && guard < 100) begin
        @(negedge clk);
        guard++;
        o_ready = 1'b1;
        #1;
        if (o_valid) begin
          check("R9 colour order", 32'(o_rgb), (got == 0) ? 32'h102030 : 32'hC0FFEE);
          got++;
        end
      end
      check("R9 count", 32'(got), 32'd4);
    end
    @(negedge clk);
    o_ready = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule